// File: doc/BRIEF.md
# SPI Master Burst Transfer Controller

This block is a register-programmed SPI master that moves whole bursts of bytes. Software works through a small memory-mapped register port. It first clears the byte FIFOs, then programs a burst length and a transmit length, loads bytes into the transmit FIFO, and finally sets a start bit. The shift engine runs clock mode 0. It sends each byte most-significant bit first and stores every byte it receives in a receive FIFO, whose fill level software can read back.

The burst length counts the bytes that are clocked on the wire. The transmit length counts how many of those bytes come from the transmit FIFO. Any later bytes go out as zero, and their received bytes are still stored. The start bit stays high for the whole exchange and clears itself once the last received byte has been stored, so software can use it as the completion flag. Chip selects can follow the exchange automatically, or software can drive the selected line to a chosen level. The polarity is programmable.

Top module: `spi_burst_ctrl`

## Requirements
- R1: After reset, control, status and read data are 0, the serial clock is low and every chip select pin is low.
- R2: The clock divider at offset 0x1C keeps bits [7:0]. The burst length at 0x20 and the transmit length at 0x24 each keep the low 24 bits of the written value. All three read back what was stored.
- R3: Writing control (offset 0x08) with bit 10 set starts an exchange only if bits 0 (enable) and 1 (master) are set in the same write. Otherwise bit 10 reads back 0 and the serial clock stays idle. When an exchange starts, bit 10 reads 1 until the last burst byte has been stored, and then it clears by itself.
- R4: Bytes go out MSB first in clock mode 0. MOSI is stable at each rising edge, and MISO is sampled on the rising edge. Each clock half period lasts divider+1 system clock cycles.
- R5: Burst bytes whose index is at or above the transmit length are sent as 0x00, and their received bytes are still stored.
- R6: Each received byte is pushed into the receive FIFO. FIFO status (offset 0x28) reports the receive level in bits [6:0] and the transmit level in bits [22:16]. Reads of offset 0x00 return the received bytes in arrival order, popping one per read.
- R7: A read of offset 0x00 while the receive FIFO is empty returns 0 and leaves the levels unchanged.
- R8: A control write with bit 8 set empties the transmit FIFO, and one with bit 9 set empties the receive FIFO. Both bits read back 0.
- R9: Control bits [13:12] pick one chip select and bit 4 marks chip selects active low. Unselected pins sit at the inactive level (high if active low, else low). If bit 16 is clear, the selected pin is active only during an exchange. If bit 16 is set, the selected pin is driven to the value of bit 17.
- R10: An exchange started with a burst length of 0 gives no serial clock edges, and bit 10 reads 0 straight away.
- R11: Each FIFO holds 64 bytes. Transmit writes to a full FIFO are dropped, and so are received bytes that arrive while the receive FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip select pins |

## Verification
- **Register reads:** a read is captured on the edge that takes the access, so the bench drives accesses on the falling edge and reads `bus_rdata` on the next falling edge.
- **Serial data:** MOSI bytes are checked at serial clock rising edges, the same instants a slave would sample. Received bytes are never checked against a fixed cycle. The bench polls the self-clearing start bit and only drains the receive FIFO after that bit reads 0, so every stored byte is already present.
- **Clock timing:** the half period is checked by timing successive rising edges inside one byte against 2×(divider+1) cycles. Gaps between bytes are left out because each byte adds one load cycle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int REG_ADDR_W = 6;
    localparam int DATA_W     = 32;

    localparam logic [REG_ADDR_W-1:0] OFS_RXD  = 6'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_TXD  = 6'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 6'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_CLK  = 6'h1C;
    localparam logic [REG_ADDR_W-1:0] OFS_BLEN = 6'h20;
    localparam logic [REG_ADDR_W-1:0] OFS_TLEN = 6'h24;
    localparam logic [REG_ADDR_W-1:0] OFS_FSTA = 6'h28;

    localparam int B_EN     = 0;
    localparam int B_MASTER = 1;
    localparam int B_ACTLOW = 4;
    localparam int B_TXCLR  = 8;
    localparam int B_RXCLR  = 9;
    localparam int B_GO     = 10;
    localparam int B_SEL_LO = 12;
    localparam int B_MAN    = 16;
    localparam int B_LVL    = 17;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_SHIFT
    } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == LVL_W'(DEPTH));
    assign level = s_q.cnt;
    assign dout  = mem_q[s_q.rp];

    always_comb begin
        s_d     = s_q;
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wp = ptr_inc(s_q.wp);
            if (pop_ok)  s_d.rp = ptr_inc(s_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wp] <= din;
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LVL_W'(DEPTH));
    p_empty_pop_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (s_q.cnt == '0));
    p_full_push_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/spi_edge_div.sv
module spi_edge_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= div) begin
            tick    = 1'b1;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_tick_only_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] tx_len,
    input  logic             tick,
    input  logic [7:0]       tx_data,
    input  logic             tx_empty,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             run,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    typedef struct packed {
        eng_state_t       st;
        logic             sclk;
        logic [2:0]       bitn;
        logic [CNT_W-1:0] idx;
        logic [7:0]       tx_sh;
        logic [7:0]       rx_sh;
    } eng_st_t;

    eng_st_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        done    = 1'b0;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (s_q.st)
            ENG_IDLE: begin
                if (start) begin
                    if (burst_len == '0) begin
                        done = 1'b1;
                    end else begin
                        s_d.st  = ENG_LOAD;
                        s_d.idx = '0;
                    end
                end
            end
            ENG_LOAD: begin
                if (s_q.idx < tx_len) begin
                    tx_pop    = 1'b1;
                    s_d.tx_sh = tx_empty ? 8'h00 : tx_data;
                end else begin
                    s_d.tx_sh = 8'h00;
                end
                s_d.bitn = '0;
                s_d.st   = ENG_SHIFT;
            end
            ENG_SHIFT: begin
                if (tick) begin
                    if (!s_q.sclk) begin
                        s_d.rx_sh = {s_q.rx_sh[6:0], miso};
                        s_d.sclk  = 1'b1;
                    end else begin
                        s_d.sclk = 1'b0;
                        if (s_q.bitn == 3'd7) begin
                            rx_push = 1'b1;
                            if ({1'b0, s_q.idx} + 1'b1 == {1'b0, burst_len}) begin
                                done   = 1'b1;
                                s_d.st = ENG_IDLE;
                            end else begin
                                s_d.idx = s_q.idx + 1'b1;
                                s_d.st  = ENG_LOAD;
                            end
                        end else begin
                            s_d.bitn  = s_q.bitn + 1'b1;
                            s_d.tx_sh = {s_q.tx_sh[6:0], 1'b0};
                        end
                    end
                end
            end
            default: s_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ENG_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign rx_data = s_q.rx_sh;
    assign run     = (s_q.st == ENG_SHIFT);
    assign busy    = (s_q.st != ENG_IDLE);
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.tx_sh[7];

    p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    p_mosi_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sclk && busy && !tick) |=> $stable(mosi));
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
    import spi_burst_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int CS_N       = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int SEL_W     = (CS_N > 1) ? $clog2(CS_N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic [CS_N-1:0]       spi_cs
);
    typedef struct packed {
        logic             en;
        logic             master;
        logic             act_low;
        logic             go;
        logic [SEL_W-1:0] sel;
        logic             man;
        logic             lvl;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] blen;
        logic [CNT_W-1:0] tlen;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic wr_en, rd_en, start;
    logic tx_flush, rx_flush, tx_push, rx_pop;
    logic [7:0] tx_head, rx_head, eng_rx_data;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic eng_tx_pop, eng_rx_push, eng_run, eng_busy, eng_done, div_tick;
    logic [DATA_W-1:0] ctrl_view, stat_view;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign tx_flush = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[B_TXCLR];
    assign rx_flush = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[B_RXCLR];
    assign tx_push  = wr_en && (bus_addr == OFS_TXD);
    assign rx_pop   = rd_en && (bus_addr == OFS_RXD);
    assign start    = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[B_GO]
                      && bus_wdata[B_EN] && bus_wdata[B_MASTER] && !r_q.go;

    always_comb begin
        ctrl_view = '0;
        ctrl_view[B_EN]     = r_q.en;
        ctrl_view[B_MASTER] = r_q.master;
        ctrl_view[B_ACTLOW] = r_q.act_low;
        ctrl_view[B_GO]     = r_q.go;
        ctrl_view[B_SEL_LO +: SEL_W] = r_q.sel;
        ctrl_view[B_MAN]    = r_q.man;
        ctrl_view[B_LVL]    = r_q.lvl;
        stat_view = '0;
        stat_view[LVL_W-1:0]   = rx_lvl;
        stat_view[16 +: LVL_W] = tx_lvl;
    end

    always_comb begin
        r_d    = r_q;
        r_d.go = (r_q.go || start) && !eng_done;
        if (wr_en) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.en      = bus_wdata[B_EN];
                    r_d.master  = bus_wdata[B_MASTER];
                    r_d.act_low = bus_wdata[B_ACTLOW];
                    r_d.sel     = bus_wdata[B_SEL_LO +: SEL_W];
                    r_d.man     = bus_wdata[B_MAN];
                    r_d.lvl     = bus_wdata[B_LVL];
                end
                OFS_CLK:  r_d.div  = bus_wdata[DIV_W-1:0];
                OFS_BLEN: r_d.blen = bus_wdata[CNT_W-1:0];
                OFS_TLEN: r_d.tlen = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (rd_en) begin
            case (bus_addr)
                OFS_RXD:  r_d.rdata = rx_empty ? '0 : DATA_W'(rx_head);
                OFS_CTRL: r_d.rdata = ctrl_view;
                OFS_CLK:  r_d.rdata = DATA_W'(r_q.div);
                OFS_BLEN: r_d.rdata = DATA_W'(r_q.blen);
                OFS_TLEN: r_d.rdata = DATA_W'(r_q.tlen);
                OFS_FSTA: r_d.rdata = stat_view;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .din(bus_wdata[7:0]),
        .pop(eng_tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_lvl)
    );

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .din(eng_rx_data),
        .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_lvl)
    );

    spi_edge_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_run), .div(r_q.div), .tick(div_tick)
    );

    spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .burst_len(r_q.blen), .tx_len(r_q.tlen), .tick(div_tick),
        .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(eng_tx_pop),
        .rx_push(eng_rx_push), .rx_data(eng_rx_data),
        .run(eng_run), .busy(eng_busy), .done(eng_done),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign spi_cs[i] = (r_q.sel == SEL_W'(i))
                           ? (r_q.man ? r_q.lvl : (eng_busy ^ r_q.act_low))
                           : r_q.act_low;
    end

    p_go_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !r_q.go);
    p_busy_under_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> r_q.go);
    p_go_needs_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.go) |-> (r_q.en && r_q.master));
    p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spi_cs ^ {CS_N{r_q.act_low}}));
    p_rx_drop_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_pop && !rx_flush) |=> rx_full);
endmodule

// File: tb/sim_spi_burst_ctrl.sv
`timescale 1ns/1ps
module sim_spi_burst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;

    int vectors = 0;
    int misses = 0;
    logic [7:0] exp_q[$];
    logic [3:0] cs_exp = 4'b0000;
    int half_exp = 0;
    int sclk_rises = 0;

    always #5 clk = ~clk;
    assign spi_miso = ~spi_mosi;

    spi_burst_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard of MOSI bytes, chip select and clock spacing.
    logic [7:0] mon_sh = '0;
    int mon_bits = 0;
    realtime last_rise = 0;
    always @(posedge spi_sclk) begin
        sclk_rises++;
        mon_sh = {mon_sh[6:0], spi_mosi};
        if (mon_bits != 0 && half_exp > 0)
            check("R4 half period", 32'($rtoi($realtime - last_rise)), 32'(half_exp * 20));
        last_rise = $realtime;
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            check("R9 cs during exchange", 32'(spi_cs), 32'(cs_exp));
            if (exp_q.size() == 0) check("R4 unexpected byte", 32'(mon_sh), 32'hxxxx);
            else check("R4 mosi byte", 32'(mon_sh), 32'(exp_q.pop_front()));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Driver: load bytes into TX FIFO, push expected wire bytes into the queue.
    task automatic send(input logic [7:0] b);
        wr(6'h04, {24'h0, b});
        exp_q.push_back(b);
    endtask

    task automatic wait_go_clear(input string req);
        logic [31:0] v;
        v = 32'h400;
        for (int k = 0; k < 4000 && v[10]; k++) rd(6'h08, v);
        check(req, {31'h0, v[10]}, 32'h0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [31:0] v;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h08, v); check("R1 ctrl", v, 32'h0);
        rd(6'h28, v); check("R1 status", v, 32'h0);
        check("R1 sclk", {31'h0, spi_sclk}, 32'h0);
        check("R1 cs", {28'h0, spi_cs}, 32'h0);

        // R2 register storage
        wr(6'h20, 32'hAB12_3456); rd(6'h20, v); check("R2 burst len", v, 32'h0012_3456);
        wr(6'h24, 32'hFF00_0007); rd(6'h24, v); check("R2 tx len", v, 32'h0000_0007);
        wr(6'h1C, 32'h0000_1202); rd(6'h1C, v); check("R2 divider", v, 32'h0000_0002);

        // R3 start ignored without enable/master
        wr(6'h20, 32'd2);
        n0 = sclk_rises;
        wr(6'h08, 32'h0000_0401);
        rd(6'h08, v); check("R3 go ignored", {31'h0, v[10]}, 32'h0);
        repeat (20) @(negedge clk);
        check("R3 no clocks", 32'(sclk_rises - n0), 32'h0);

        // R4 R6 R9 three-byte burst on select 2, active high, divider 2
        half_exp = 3;
        cs_exp = 4'b0100;
        wr(6'h20, 32'd3); wr(6'h24, 32'd3);
        send(8'hA5); send(8'h3C); send(8'hF0);
        wr(6'h08, 32'h0000_2403);
        rd(6'h08, v); check("R3 go set while busy", {31'h0, v[10]}, 32'h1);
        wait_go_clear("R3 go self clears");
        check("R4 all bytes seen", 32'(exp_q.size()), 32'h0);
        rd(6'h28, v); check("R6 rx level", v, 32'h3);
        rd(6'h00, v); check("R6 rx byte 0", v, 32'h5A);
        rd(6'h00, v); check("R6 rx byte 1", v, 32'hC3);
        rd(6'h00, v); check("R6 rx byte 2", v, 32'h0F);
        rd(6'h00, v); check("R7 empty read", v, 32'h0);
        rd(6'h28, v); check("R7 level unchanged", v, 32'h0);
        check("R9 cs idle", {28'h0, spi_cs}, 32'h0);

        // R5 tail bytes are zero, still captured
        wr(6'h24, 32'd1);
        send(8'h11); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        wr(6'h08, 32'h0000_2403);
        wait_go_clear("R5 go clears");
        rd(6'h28, v); check("R5 rx level", v, 32'h3);
        rd(6'h00, v); check("R5 rx byte 0", v, 32'hEE);
        rd(6'h00, v); check("R5 rx zero byte", v, 32'hFF);
        rd(6'h00, v); check("R5 rx zero byte", v, 32'hFF);

        // R8 FIFO clears
        wr(6'h04, 32'h1); wr(6'h04, 32'h2);
        rd(6'h28, v); check("R8 tx level before", v, 32'h0002_0000);
        wr(6'h08, 32'h0000_0103);
        rd(6'h28, v); check("R8 tx cleared", v, 32'h0);
        rd(6'h08, v); check("R8 clear bits read 0", v & 32'h300, 32'h0);
        wr(6'h24, 32'd0); wr(6'h20, 32'd2);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        cs_exp = 4'b0001;
        wr(6'h08, 32'h0000_0403);
        wait_go_clear("R8 go clears");
        rd(6'h28, v); check("R8 rx level before", v, 32'h2);
        wr(6'h08, 32'h0000_0203);
        rd(6'h28, v); check("R8 rx cleared", v, 32'h0);

        // R10 zero-length burst
        wr(6'h20, 32'd0);
        n0 = sclk_rises;
        wr(6'h08, 32'h0000_0403);
        rd(6'h08, v); check("R10 go reads 0", {31'h0, v[10]}, 32'h0);
        repeat (10) @(negedge clk);
        check("R10 no clocks", 32'(sclk_rises - n0), 32'h0);

        // R9 manual chip select, active low, select 1
        wr(6'h08, 32'h0003_1013); @(negedge clk);
        check("R9 manual level high", {28'h0, spi_cs}, 32'hF);
        wr(6'h08, 32'h0001_1013); @(negedge clk);
        check("R9 manual level low", {28'h0, spi_cs}, 32'hD);
        wr(6'h08, 32'h0000_1013); @(negedge clk);
        check("R9 auto active low idle", {28'h0, spi_cs}, 32'hF);

        // R11 FIFO depth 64
        for (int k = 0; k < 70; k++) wr(6'h04, 32'(k));
        rd(6'h28, v); check("R11 tx level capped", v, 32'h0040_0000);
        wr(6'h08, 32'h0000_0103);
        wr(6'h1C, 32'd0); half_exp = 1;
        wr(6'h24, 32'd0); wr(6'h20, 32'd66);
        cs_exp = 4'b0001;
        for (int k = 0; k < 66; k++) exp_q.push_back(8'h00);
        wr(6'h08, 32'h0000_0403);
        wait_go_clear("R11 go clears");
        rd(6'h28, v); check("R11 rx level capped", v, 32'h40);
        rd(6'h00, v); check("R11 rx data", v, 32'hFF);
        check("R11 all bytes seen", 32'(exp_q.size()), 32'h0);

        summary();
    end
endmodule